// File: doc/BRIEF.md
# Doorbell Request Slot Dispatcher

This block keeps two pending-request bitmaps, one for ordinary transfer requests and one for task-management requests. Software starts a request by writing a mask to the matching bitmap. Every bit that goes from clear to set names a slot that is now owned by hardware. The block records the order in which slots were rung, separately for each list. It then hands the slots one at a time to a single downstream execution engine over a valid/ready port. Task-management work always goes out ahead of transfer work.

The downstream engine reports each finished slot on a completion input, in any order. That report clears the slot's bit. A read of either bitmap shows every slot that is still queued or still executing. Software can therefore find finished slots by XOR against its own copy. New slots may be rung at any time, including while earlier ones are still running.

Top module: `doorbell_dispatch`

## Requirements
- R1: After reset both bitmaps read as zero and `disp_valid` is low.
- R2: A write sets, in the selected bitmap (`reg_wr_sel` 0 = transfer, 1 = task management), every slot whose `reg_wr_data` bit is one. Zero bits leave their slots unchanged. The new value is visible on `reg_rd_data` from the cycle after the write.
- R3: Within one list, slots are dispatched in the order of the writes that rang them, whatever their slot numbers.
- R4: When one write rings several slots, they are dispatched lowest slot number first.
- R5: Ringing a slot whose bit is already set has no effect, and the slot is dispatched only once.
- R6: While any task-management slot waits for dispatch, `disp_kind` is 1 and no transfer slot is dispatched.
- R7: A slot's bit stays set after dispatch until a completion (`cpl_valid`, `cpl_kind`, `cpl_tag`) names it. The completion clears that bit on the next cycle, and completions may come in any order.
- R8: While `disp_valid` is high and `disp_ready` is low, the offered kind and tag stay stable. An entry is consumed only in a cycle where both are high. The exception is a new task-management ring, which may take over the port.
- R9: A write that rings new slots in the same cycle as a dispatch handshake loses neither. The new slots queue behind the entries that remain.
- R10: A write or completion for one list never changes the other list's bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Bitmap write strobe |
| reg_wr_sel | input | 1 | Bitmap written: 0 transfer, 1 task management |
| reg_wr_data | input | SLOTS | Mask of slots to ring |
| reg_rd_sel | input | 1 | Bitmap read: 0 transfer, 1 task management |
| reg_rd_data | output | SLOTS | Current pending-or-executing bitmap |
| disp_valid | output | 1 | A slot is offered downstream |
| disp_ready | input | 1 | Downstream accepts the offered slot |
| disp_kind | output | 1 | List of the offered slot: 1 task management |
| disp_tag | output | TW | Slot number offered |
| cpl_valid | input | 1 | Completion strobe |
| cpl_kind | input | 1 | List of the completed slot |
| cpl_tag | input | TW | Slot number completed |

## Verification
A dispatch handshake can pop the head of a list's order queue in the same cycle as a write appends newly rung slots to that queue. Completions and rings can also hit the same cycle. The bench makes this happen by raising `disp_ready` and `reg_wr_en` together on one edge while a slot is already being offered. It then judges the outcome by the exact sequence of tags that follow on the dispatch port, and by the bitmap read back. Out-of-order completion is tested by finishing slots in an order unrelated to dispatch order, and reading the bitmap after each completion.

// File: rtl/doorbell_dispatch.sv
module doorbell_dispatch #(
  parameter int SLOTS = 8,
  localparam int TW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_wr_sel,
  input  logic [SLOTS-1:0] reg_wr_data,
  input  logic             reg_rd_sel,
  output logic [SLOTS-1:0] reg_rd_data,
  output logic             disp_valid,
  input  logic             disp_ready,
  output logic             disp_kind,
  output logic [TW-1:0]    disp_tag,
  input  logic             cpl_valid,
  input  logic             cpl_kind,
  input  logic [TW-1:0]    cpl_tag
);

  logic [1:0][SLOTS-1:0] bell_q, bell_d;
  logic [TW-1:0]         ord_q [2][SLOTS];
  logic [TW-1:0]         ord_d [2][SLOTS];
  logic [CW-1:0]         cnt_q [2];
  logic [CW-1:0]         cnt_d [2];

  assign disp_kind   = (cnt_q[1] != '0);
  assign disp_valid  = disp_kind || (cnt_q[0] != '0);
  assign disp_tag    = disp_kind ? ord_q[1][0] : ord_q[0][0];
  assign reg_rd_data = bell_q[reg_rd_sel];

  always_comb begin : next_state
    logic [SLOTS-1:0] fresh, done;
    logic             pop;
    logic [CW-1:0]    pos;
    for (int l = 0; l < 2; l++) begin
      fresh = (reg_wr_en && reg_wr_sel == 1'(l)) ? (reg_wr_data & ~bell_q[l]) : '0;
      done  = (cpl_valid && cpl_kind == 1'(l)) ? (SLOTS'(1) << cpl_tag) : '0;
      bell_d[l] = (bell_q[l] & ~done) | fresh;
      pop = disp_valid && disp_ready && (disp_kind == 1'(l));
      for (int i = 0; i < SLOTS; i++)
        ord_d[l][i] = (pop && i < SLOTS - 1) ? ord_q[l][(i + 1) % SLOTS] : ord_q[l][i];
      pos = cnt_q[l] - CW'(pop);
      for (int b = 0; b < SLOTS; b++) begin
        if (fresh[b]) begin
          ord_d[l][pos[TW-1:0]] = TW'(b);
          pos = pos + 1'b1;
        end
      end
      cnt_d[l] = pos;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bell_q <= '0;
      for (int l = 0; l < 2; l++) begin
        cnt_q[l] <= '0;
        for (int i = 0; i < SLOTS; i++) ord_q[l][i] <= '0;
      end
    end else begin
      bell_q <= bell_d;
      for (int l = 0; l < 2; l++) begin
        cnt_q[l] <= cnt_d[l];
        for (int i = 0; i < SLOTS; i++) ord_q[l][i] <= ord_d[l][i];
      end
    end
  end

endmodule

// File: rtl/doorbell_dispatch_chk.sv
module doorbell_dispatch_chk #(
  parameter int SLOTS = 8,
  parameter int TW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic             reg_wr_sel,
  input logic [SLOTS-1:0] reg_wr_data,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic             disp_kind,
  input logic [TW-1:0]    disp_tag,
  input logic             cpl_valid,
  input logic             cpl_kind,
  input logic [TW-1:0]    cpl_tag,
  input logic [1:0][SLOTS-1:0] bell_q
);

  // R8
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready && !(reg_wr_en && reg_wr_sel)
    |=> disp_valid && $stable(disp_kind) && $stable(disp_tag));

  // R7
  offered_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> bell_q[disp_kind][disp_tag]);

  // R7
  cpl_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !(reg_wr_en && reg_wr_sel == cpl_kind)
    |=> !bell_q[$past(cpl_kind)][$past(cpl_tag)]);

  // R2
  ring_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && !(cpl_valid && cpl_kind == reg_wr_sel)
    |=> (bell_q[$past(reg_wr_sel)] & $past(reg_wr_data)) == $past(reg_wr_data));

  // R10
  other_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && !reg_wr_sel && !(cpl_valid && cpl_kind)
    |=> $stable(bell_q[1]));

endmodule

bind doorbell_dispatch doorbell_dispatch_chk #(.SLOTS(SLOTS), .TW(TW)) u_chk (.*);

// File: tb/tb_doorbell_dispatch.sv
module tb_doorbell_dispatch;
  localparam int SLOTS = 8;
  localparam int TW = 3;

  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0, reg_wr_sel = 0, reg_rd_sel = 0;
  logic [SLOTS-1:0] reg_wr_data = '0, reg_rd_data;
  logic disp_valid, disp_ready = 0, disp_kind;
  logic [TW-1:0] disp_tag;
  logic cpl_valid = 0, cpl_kind = 0;
  logic [TW-1:0] cpl_tag = '0;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  doorbell_dispatch #(.SLOTS(SLOTS)) dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1; n_chk = n_chk + 1;
      $display("FAIL watchdog: act=%0d exp=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic ring(input logic sel, input logic [SLOTS-1:0] m);
    reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = m;
    @(posedge clk); @(negedge clk);
    reg_wr_en = 0; reg_wr_data = '0;
  endtask

  task automatic rd(input logic sel, input logic [SLOTS-1:0] exp, input string req);
    reg_rd_sel = sel; #1;
    chk(reg_rd_data == exp, req, reg_rd_data, exp);
  endtask

  task automatic take(input logic k, input logic [TW-1:0] t, input string req);
    chk(disp_valid && disp_kind == k && disp_tag == t, req,
        {disp_valid, disp_kind, 1'b0, disp_tag}, {1'b1, k, 1'b0, t});
    disp_ready = 1;
    @(posedge clk); @(negedge clk);
    disp_ready = 0;
  endtask

  task automatic done(input logic k, input logic [TW-1:0] t);
    cpl_valid = 1; cpl_kind = k; cpl_tag = t;
    @(posedge clk); @(negedge clk);
    cpl_valid = 0;
  endtask

  task automatic t_reset;
    rd(0, 8'h00, "R1 xfer");
    rd(1, 8'h00, "R1 tm");
    chk(!disp_valid, "R1 valid", disp_valid, 0);
  endtask

  task automatic t_order;
    ring(0, 8'h20);
    ring(0, 8'h02);
    ring(0, 8'h00);
    ring(0, 8'h09);
    rd(0, 8'h2b, "R2 bitmap");
    take(0, 5, "R3 first");
    take(0, 1, "R3 second");
    take(0, 0, "R4 low first");
    take(0, 3, "R4 next");
    chk(!disp_valid, "R3 drained", disp_valid, 0);
    rd(0, 8'h2b, "R7 held while executing");
  endtask

  task automatic t_complete;
    done(0, 1); rd(0, 8'h29, "R7 clear 1");
    done(0, 5); rd(0, 8'h09, "R7 clear 5");
    done(0, 3); rd(0, 8'h01, "R7 clear 3");
    done(0, 0); rd(0, 8'h00, "R7 clear 0");
  endtask

  task automatic t_rering;
    ring(0, 8'h04);
    ring(0, 8'h04);
    rd(0, 8'h04, "R5 bitmap");
    take(0, 2, "R5 once");
    chk(!disp_valid, "R5 no repeat", disp_valid, 0);
    ring(0, 8'h04);
    chk(!disp_valid, "R5 executing slot rung", disp_valid, 0);
    done(0, 2);
  endtask

  task automatic t_priority;
    ring(0, 8'h03);
    ring(1, 8'h80);
    rd(0, 8'h03, "R10 xfer");
    rd(1, 8'h80, "R10 tm");
    take(1, 7, "R6 tm first");
    take(0, 0, "R6 xfer after");
    ring(1, 8'h10);
    take(1, 4, "R6 late tm jumps");
    take(0, 1, "R6 xfer last");
    done(1, 7); rd(0, 8'h03, "R10 tm cpl");
    rd(1, 8'h10, "R7 tm clear");
    done(1, 4); done(0, 0); done(0, 1);
    rd(0, 8'h00, "R7 all clear");
  endtask

  task automatic t_hold;
    ring(0, 8'h10);
    repeat (3) @(negedge clk);
    chk(disp_valid && disp_tag == 4, "R8 hold", disp_tag, 4);
    take(0, 4, "R8 take");
    chk(!disp_valid, "R8 consumed", disp_valid, 0);
    done(0, 4);
  endtask

  task automatic t_same_cycle;
    ring(0, 8'h01);
    chk(disp_valid && disp_tag == 0, "R9 offered", disp_tag, 0);
    disp_ready = 1; reg_wr_en = 1; reg_wr_sel = 0; reg_wr_data = 8'h06;
    cpl_valid = 1; cpl_kind = 1; cpl_tag = 0;
    @(posedge clk); @(negedge clk);
    disp_ready = 0; reg_wr_en = 0; reg_wr_data = '0; cpl_valid = 0;
    rd(0, 8'h07, "R9 bitmap");
    take(0, 1, "R9 next");
    take(0, 2, "R9 last");
    chk(!disp_valid, "R9 drained", disp_valid, 0);
    done(0, 0); done(0, 2); done(0, 1);
    rd(0, 8'h00, "R9 clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_complete();
    t_rering();
    t_priority();
    t_hold();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule